// File: doc/BRIEF.md
# Timer-Reload Serial Baud Generator

This block turns the system oscillator clock into the bit-rate strobes a UART needs. A fixed divide-by-12 prescaler advances an 8-bit up-counter. When the counter wraps past its all-ones value it reloads from a programmable byte, so it overflows once every (256 − reload) prescaled ticks. A shared post-divider then divides those overflows by 32, or by 16 when the rate-doubling input is set. The resulting bit rate is 2^dbl × Fosc / (32 × 12 × (256 − reload)).

A select input chooses the pulse that drives the post-divider: the timer overflow, or a tick from another internal rate generator that arrives on an input. The block gives two single-cycle enables, both synchronous to the oscillator clock. One marks the bit rate. The other runs 16 times faster and serves as the oversampling strobe for a receiver. The prescaler and timer keep running whichever source is selected.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous active-high reset clears the prescaler, the timer counter and the post-divider. During reset and in the cycle after it, both outputs are 0. After reset the timer starts from 0.
- R2: The timer counter advances exactly once every 12 oscillator cycles, and a timer overflow occurs only on such a prescaled tick.
- R3: With the timer selected, an overflow happens when a prescaled tick meets counter value 255. The counter then loads `reload_val`, so later overflows are (256 − reload_val) prescaled ticks apart.
- R4: With `dbl_rate` = 0, `bit_tick` pulses once every 32 source pulses.
- R5: With `dbl_rate` = 1, `bit_tick` pulses once every 16 source pulses. `tick_16x` pulses on every source pulse, one clock after the pulse.
- R6: With `src_sel` = 1, `alt_tick` drives the post-divider in place of the timer overflow. With `src_sel` = 0, `alt_tick` has no effect on the outputs.
- R7: A new `reload_val` written while the timer runs does not change the current count. It is first loaded at the next overflow.
- R8: With `dbl_rate` = 0, `tick_16x` pulses on every second source pulse. Every `bit_tick` pulse coincides with a `tick_16x` pulse.
- R9: Both outputs are registered. Each is high for exactly one clock per source pulse that produces it, in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_val | input | 8 | Byte loaded into the timer on overflow |
| dbl_rate | input | 1 | 1: post-divide by 16, 0: post-divide by 32 |
| src_sel | input | 1 | 0: timer overflow drives the divider, 1: alt_tick drives it |
| alt_tick | input | 1 | Single-cycle tick from the alternate rate generator |
| tick_16x | output | 1 | Oversampling enable, 16 per bit period |
| bit_tick | output | 1 | Bit-rate enable |

## Verification
A wrong prescaler or timer count moves every later overflow. The first `tick_16x` pulse then comes a cycle or more early or late, and a cycle-exact reference catches this on the first overflow after the fault. A post-divider fault shows as a misplaced `bit_tick` within at most 32 source pulses. A wrong parity in the divider shows as a missing or extra `tick_16x` on the next source pulse. A reload taken at the wrong moment changes only the interval that follows, so the bench writes the new reload in the middle of a count and compares every cycle of the interval after it.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int PRESCALE_DIV = 12;
    localparam int TIMER_W      = 8;
    localparam int POST_W       = 5;

    typedef struct packed {
        logic os_tick;
        logic bit_tick;
    } rate_pulse_t;

    // True when a post-divider count is the last phase of a bit period.
    function automatic logic at_bit_edge(input logic [POST_W-1:0] cnt,
                                         input logic dbl);
        logic [POST_W-1:0] mask;
        mask = dbl ? {1'b0, {(POST_W-1){1'b1}}} : {POST_W{1'b1}};
        return (cnt & mask) == mask;
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] count;

    assign tick = (count == LAST);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= '0;
        else           count <= count + 1'b1;
    end
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] reload,
    output logic         ovf
);
    logic [W-1:0] count;

    assign ovf = step && (count == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (ovf)  count <= reload;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/baud_post_div.sv
module baud_post_div
    import baud_pkg::*;
#(
    parameter int W = POST_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        src,
    input  logic        dbl,
    output rate_pulse_t pulse
);
    logic [W-1:0] phase;
    rate_pulse_t  nxt;

    always_comb begin
        nxt.os_tick  = src && (dbl || phase[0]);
        nxt.bit_tick = src && at_bit_edge(phase, dbl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            pulse <= '0;
        end else begin
            pulse <= nxt;
            if (src) phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int PRE_DIV = PRESCALE_DIV,
    parameter int CNT_W   = TIMER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             dbl_rate,
    input  logic             src_sel,
    input  logic             alt_tick,
    output logic             tick_16x,
    output logic             bit_tick
);
    logic        pre_tick;
    logic        timer_ovf;
    logic        src_pulse;
    rate_pulse_t pulses;

    baud_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (pre_tick)
    );

    baud_reload_timer #(.W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .step   (pre_tick),
        .reload (reload_val),
        .ovf    (timer_ovf)
    );

    assign src_pulse = src_sel ? alt_tick : timer_ovf;

    baud_post_div #(.W(POST_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .src   (src_pulse),
        .dbl   (dbl_rate),
        .pulse (pulses)
    );

    assign tick_16x = pulses.os_tick;
    assign bit_tick = pulses.bit_tick;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk (
    input logic clk,
    input logic rst,
    input logic dbl_rate,
    input logic src_sel,
    input logic alt_tick,
    input logic pre_tick,
    input logic timer_ovf,
    input logic tick_16x,
    input logic bit_tick
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!tick_16x && !bit_tick));

    // R2
    ovf_on_pre_chk: assert property (@(posedge clk) disable iff (rst) timer_ovf |-> pre_tick);

    // R5
    dbl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_ovf && !src_sel && dbl_rate) |=> tick_16x);

    // R6
    alt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel && !alt_tick) |=> (!tick_16x && !bit_tick));

    // R8
    bit_in_os_chk: assert property (@(posedge clk) disable iff (rst) bit_tick |-> tick_16x);
endmodule

bind baud_tick_gen baud_tick_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbl_rate  (dbl_rate),
    .src_sel   (src_sel),
    .alt_tick  (alt_tick),
    .pre_tick  (pre_tick),
    .timer_ovf (timer_ovf),
    .tick_16x  (tick_16x),
    .bit_tick  (bit_tick)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reload_val = 8'd255;
    logic       dbl_rate = 1'b1;
    logic       src_sel = 1'b0;
    logic       alt_tick = 1'b0;
    logic       tick_16x, bit_tick;

    int compared = 0;
    int mismatched = 0;
    int cycle = 0;
    bit started = 0;
    bit done = 0;
    string phase_req = "R1";

    baud_tick_gen uut (
        .clk(clk), .rst(rst), .reload_val(reload_val), .dbl_rate(dbl_rate),
        .src_sel(src_sel), .alt_tick(alt_tick),
        .tick_16x(tick_16x), .bit_tick(bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: integer counters, expected outputs one clock late.
    int m_pre = 0, m_tmr = 0, m_div = 0;
    bit m_os = 0, m_bit = 0;

    always @(posedge clk) begin
        bit fire, ovf, src;
        cycle++;
        started = 1;
        if (rst) begin
            m_pre = 0; m_tmr = 0; m_div = 0; m_os = 0; m_bit = 0;
        end else begin
            fire = (m_pre == 11);
            m_pre = fire ? 0 : m_pre + 1;
            ovf = fire && (m_tmr == 255);
            if (fire) m_tmr = ovf ? int'(reload_val) : m_tmr + 1;
            src = src_sel ? alt_tick : ovf;
            m_os  = src && (dbl_rate || (m_div % 2 == 1));
            m_bit = src && (dbl_rate ? (m_div % 16 == 15) : (m_div == 31));
            if (src) m_div = (m_div + 1) % 32;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            compared++;
            if (tick_16x !== m_os || bit_tick !== m_bit) begin
                mismatched++;
                $display("FAIL %s cycle %0d: actual tick_16x=%b bit_tick=%b expected %b %b",
                         phase_req, cycle, tick_16x, bit_tick, m_os, m_bit);
            end
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles between two successive high samples of the chosen output.
    task automatic period_of(input bit use_bit, output int per);
        int t0;
        do @(negedge clk); while (!(use_bit ? bit_tick : tick_16x));
        t0 = cycle;
        do @(negedge clk); while (!(use_bit ? bit_tick : tick_16x));
        per = cycle - t0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog (R1..R9 run): actual timeout expected completion");
        finish_run();
    end

    // Alternate source: one pulse every 5 clocks.
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            alt_tick = 1'b1;
            @(negedge clk);
            alt_tick = 1'b0;
        end
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        // R1: outputs low during and right after reset
        check_eq("R1 os in reset", int'(tick_16x), 0);
        check_eq("R1 bit in reset", int'(bit_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 os after reset", int'(tick_16x), 0);

        // R2 R3: first overflow only after the counter runs up from 0
        phase_req = "R3";
        period_of(1'b0, per);
        check_eq("R2 16x period reload 255 dbl", per, 12);
        phase_req = "R5";
        period_of(1'b1, per);
        check_eq("R5 bit period dbl reload 255", per, 192);

        // R4 R8: no doubling
        phase_req = "R8";
        dbl_rate = 1'b0;
        period_of(1'b0, per);
        period_of(1'b0, per);
        check_eq("R8 16x every second overflow", per, 24);
        phase_req = "R4";
        period_of(1'b1, per);
        period_of(1'b1, per);
        check_eq("R4 bit period /32", per, 384);

        // R7: reload change in mid-count, applied from the next overflow
        phase_req = "R7";
        reload_val = 8'd250;
        period_of(1'b0, per);
        period_of(1'b0, per);
        check_eq("R7 R3 16x period reload 250", per, 144);
        dbl_rate = 1'b1;
        period_of(1'b0, per);
        period_of(1'b0, per);
        check_eq("R3 dbl period reload 250", per, 72);

        // R6: alternate source
        phase_req = "R6";
        src_sel = 1'b1;
        period_of(1'b0, per);
        period_of(1'b0, per);
        check_eq("R6 alt 16x period", per, 5);
        period_of(1'b1, per);
        check_eq("R6 alt bit period", per, 80);
        dbl_rate = 1'b0;
        period_of(1'b1, per);
        period_of(1'b1, per);
        check_eq("R6 alt bit period /32", per, 160);
        src_sel = 1'b0;
        phase_req = "R9";
        repeat (400) @(negedge clk);

        // R1: reset in mid-run
        phase_req = "R1";
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 quiet after mid reset", int'(tick_16x | bit_tick), 0);
        repeat (3200) @(negedge clk);
        finish_run();
    end
endmodule